// File: doc/BRIEF.md
# External Oscillator Failure Guard

This block watches a fast external oscillator clock from the domain of a slower, always-running internal reference clock. While software has turned monitoring on and the oscillator reports that its startup time is over, the guard checks that the external clock keeps producing edges. If a whole observation window of reference cycles passes with no edge, the clock is treated as dead.

A detected failure does more than raise a flag. The guard asks for the external oscillator to be switched off. If the system clock was derived from that oscillator, directly or through a PLL fed by it, the guard forces the system clock over to the internal oscillator. When the PLL is on that path, the guard also asks for the PLL to be switched off. It sends a one-cycle break pulse to a timer and sets a sticky non-maskable interrupt flag that software clears by writing 1. The oscillators, the PLL and the glitch-free clock multiplexer are outside the block; they appear only as request and select pins.

Inside the external domain, a small divider toggles a flag that a synchronizer brings into the reference domain. A window counter looks for toggles there, and a reaction stage turns a failure into the requests and flags above.

Top module: `clk_guard`

## Requirements
- R1: After reset, osc_off_req, pll_off_req, force_int_sel, brk_pulse and nmi_flag are all 0.
- R2: While the guard is armed (mon_en=1, osc_ready=1, no failure pending) and the external clock runs, no failure is raised.
- R3: When the external clock stops while the guard is armed, nmi_flag and osc_off_req become 1 within 2*WIN_CYC+8 reference cycles.
- R4: With sys_src=2'b01 (external oscillator) at failure, force_int_sel becomes 1 and pll_off_req stays 0.
- R5: With sys_src=2'b10 (PLL) and pll_from_ext=1 at failure, both force_int_sel and pll_off_req become 1.
- R6: With sys_src=2'b00 (internal), or sys_src=2'b10 with pll_from_ext=0, a failure raises only osc_off_req and nmi_flag, and force_int_sel and pll_off_req stay 0.
- R7: brk_pulse is high for exactly one reference cycle per failure. It is high in the first cycle in which nmi_flag is 1.
- R8: nmi_flag stays 1 until a cycle with nmi_clr=1. In that cycle it clears unless a new failure is raised in the same cycle, in which case the new failure wins.
- R9: With mon_en=0, or with osc_ready=0, a stopped external clock raises no failure.
- R10: After a failure the guard stays disarmed until osc_restart is pulsed and osc_ready has been seen low and then high again. The osc_restart pulse clears osc_off_req, force_int_sel and pll_off_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Internal reference clock; all outputs are in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | Monitored external oscillator clock |
| mon_en | input | 1 | Software enable for monitoring |
| osc_ready | input | 1 | External oscillator startup delay has elapsed |
| osc_restart | input | 1 | Software re-enables the oscillator (one-cycle pulse) |
| sys_src | input | 2 | System clock source: 00 internal, 01 external, 10 PLL, 11 treated as internal |
| pll_from_ext | input | 1 | PLL input is the external oscillator, divided or not |
| nmi_clr | input | 1 | Write-1 clear of the interrupt flag |
| osc_off_req | output | 1 | Request to disable the external oscillator |
| pll_off_req | output | 1 | Request to disable the PLL |
| force_int_sel | output | 1 | Forces the system clock onto the internal oscillator |
| brk_pulse | output | 1 | One-cycle break event to a timer |
| nmi_flag | output | 1 | Sticky non-maskable interrupt flag |

## Verification
The main function is tried with four pairs of clock-source select and PLL input source, and in each case the external clock is stopped while the guard is armed. Comparing the outputs across these cases shows whether the forced switch and the PLL disable follow the clock path or fire on every failure. The guard is also held with a running clock over many windows, which exposes false detections. A stopped clock is then applied with either arming condition missing, and again right after a failure without a new ready cycle, which shows whether the guard respects each of its arming conditions.

// File: rtl/clk_guard_pkg.sv
package clk_guard_pkg;
  typedef enum logic [1:0] {
    SRC_INT = 2'b00,
    SRC_EXT = 2'b01,
    SRC_PLL = 2'b10,
    SRC_RSV = 2'b11
  } sys_src_e;

  function automatic logic src_uses_ext(input logic [1:0] sel, input logic pll_ext);
    case (sys_src_e'(sel))
      SRC_EXT: return 1'b1;
      SRC_PLL: return pll_ext;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic src_uses_pll(input logic [1:0] sel, input logic pll_ext);
    return (sys_src_e'(sel) == SRC_PLL) && pll_ext;
  endfunction
endpackage

// File: rtl/clk_guard_sync.sv
module clk_guard_sync #(
  parameter int DIV_W  = 2,
  parameter int STAGES = 2
) (
  input  logic ext_clk,
  input  logic ref_clk,
  input  logic rst_n,
  output logic edge_seen
);
  localparam logic [DIV_W-1:0] DIV_TOP = '1;

  logic [DIV_W-1:0] div_q;
  logic             tog_q;

  always_ff @(posedge ext_clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      tog_q <= 1'b0;
    end else begin
      div_q <= div_q + 1'b1;
      if (div_q == DIV_TOP) tog_q <= ~tog_q;
    end
  end

  logic [STAGES:0] chain_q;

  genvar gi;
  generate
    for (gi = 0; gi <= STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge ref_clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= tog_q;
        end
      end else begin : g_next
        always_ff @(posedge ref_clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b0;
          else        chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign edge_seen = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/clk_guard_window.sv
module clk_guard_window #(
  parameter int WIN_CYC = 16
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic armed,
  input  logic edge_seen,
  output logic fail
);
  localparam int CW = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          hit_q;
  logic          fail_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hit_q  <= 1'b0;
      fail_q <= 1'b0;
    end else if (!armed) begin
      cnt_q  <= '0;
      hit_q  <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      fail_q <= 1'b0;
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        hit_q <= 1'b0;
        if (!hit_q && !edge_seen) fail_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (edge_seen) hit_q <= 1'b1;
      end
    end
  end

  assign fail = fail_q;
endmodule

// File: rtl/clk_guard_react.sv
module clk_guard_react
  import clk_guard_pkg::*;
(
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       fail,
  input  logic       mon_en,
  input  logic       osc_ready,
  input  logic       osc_restart,
  input  logic [1:0] sys_src,
  input  logic       pll_from_ext,
  input  logic       nmi_clr,
  output logic       armed,
  output logic       osc_off_req,
  output logic       pll_off_req,
  output logic       force_int_sel,
  output logic       brk_pulse,
  output logic       nmi_flag
);
  logic osc_off_q, pll_off_q, force_q, brk_q, nmi_q, wait_low_q;

  assign armed = mon_en && osc_ready && !osc_off_q && !wait_low_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_off_q  <= 1'b0;
      pll_off_q  <= 1'b0;
      force_q    <= 1'b0;
      brk_q      <= 1'b0;
      nmi_q      <= 1'b0;
      wait_low_q <= 1'b0;
    end else begin
      brk_q <= fail;
      if (fail) begin
        osc_off_q  <= 1'b1;
        wait_low_q <= 1'b1;
        nmi_q      <= 1'b1;
        if (src_uses_ext(sys_src, pll_from_ext)) force_q   <= 1'b1;
        if (src_uses_pll(sys_src, pll_from_ext)) pll_off_q <= 1'b1;
      end else begin
        if (nmi_clr)     nmi_q <= 1'b0;
        if (!osc_ready)  wait_low_q <= 1'b0;
        if (osc_restart) begin
          osc_off_q <= 1'b0;
          pll_off_q <= 1'b0;
          force_q   <= 1'b0;
        end
      end
    end
  end

  assign osc_off_req   = osc_off_q;
  assign pll_off_req   = pll_off_q;
  assign force_int_sel = force_q;
  assign brk_pulse     = brk_q;
  assign nmi_flag      = nmi_q;
endmodule

// File: rtl/clk_guard.sv
module clk_guard #(
  parameter int WIN_CYC = 16,
  parameter int DIV_W   = 2,
  parameter int STAGES  = 2
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       ext_clk,
  input  logic       mon_en,
  input  logic       osc_ready,
  input  logic       osc_restart,
  input  logic [1:0] sys_src,
  input  logic       pll_from_ext,
  input  logic       nmi_clr,
  output logic       osc_off_req,
  output logic       pll_off_req,
  output logic       force_int_sel,
  output logic       brk_pulse,
  output logic       nmi_flag
);
  logic edge_seen, armed, fail;

  clk_guard_sync #(.DIV_W(DIV_W), .STAGES(STAGES)) u_sync (
    .ext_clk   (ext_clk),
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .edge_seen (edge_seen)
  );

  clk_guard_window #(.WIN_CYC(WIN_CYC)) u_win (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .armed     (armed),
    .edge_seen (edge_seen),
    .fail      (fail)
  );

  clk_guard_react u_react (
    .ref_clk       (ref_clk),
    .rst_n         (rst_n),
    .fail          (fail),
    .mon_en        (mon_en),
    .osc_ready     (osc_ready),
    .osc_restart   (osc_restart),
    .sys_src       (sys_src),
    .pll_from_ext  (pll_from_ext),
    .nmi_clr       (nmi_clr),
    .armed         (armed),
    .osc_off_req   (osc_off_req),
    .pll_off_req   (pll_off_req),
    .force_int_sel (force_int_sel),
    .brk_pulse     (brk_pulse),
    .nmi_flag      (nmi_flag)
  );
endmodule

// File: rtl/clk_guard_chk.sv
module clk_guard_chk (
  input logic ref_clk,
  input logic rst_n,
  input logic osc_restart,
  input logic nmi_clr,
  input logic osc_off_req,
  input logic pll_off_req,
  input logic force_int_sel,
  input logic brk_pulse,
  input logic nmi_flag
);
  // R7: break lasts a single cycle
  p_brk_single_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    brk_pulse |=> !brk_pulse);
  // R7: break coincides with the flag being set
  p_brk_with_nmi_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    brk_pulse |-> nmi_flag);
  // R8: flag holds without a clear
  p_nmi_sticky_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (nmi_flag && !nmi_clr) |=> nmi_flag);
  // R8: flag only rises together with a break
  p_nmi_rise_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(nmi_flag) |-> brk_pulse);
  // R5: PLL disable only together with forced switch
  p_pll_implies_force_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pll_off_req |-> (force_int_sel && osc_off_req));
  // R10: requests hold until restart
  p_kill_hold_r10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (osc_off_req && !osc_restart) |=> osc_off_req);
endmodule

bind clk_guard clk_guard_chk u_chk (
  .ref_clk       (ref_clk),
  .rst_n         (rst_n),
  .osc_restart   (osc_restart),
  .nmi_clr       (nmi_clr),
  .osc_off_req   (osc_off_req),
  .pll_off_req   (pll_off_req),
  .force_int_sel (force_int_sel),
  .brk_pulse     (brk_pulse),
  .nmi_flag      (nmi_flag)
);

// File: tb/clk_guard_test.sv
module clk_guard_test;
  localparam int WIN = 16;
  localparam int LAT = 2 * WIN + 8;

  logic ref_clk = 1'b0, rst_n = 1'b0, ext_clk = 1'b0, ext_run = 1'b0;
  logic mon_en = 1'b0, osc_ready = 1'b0, osc_restart = 1'b0, pll_from_ext = 1'b0, nmi_clr = 1'b0;
  logic [1:0] sys_src = 2'b00;
  logic osc_off_req, pll_off_req, force_int_sel, brk_pulse, nmi_flag;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 ref_clk = ~ref_clk;
  always begin
    #3;
    if (ext_run) ext_clk = ~ext_clk;
  end

  clk_guard #(.WIN_CYC(WIN)) uut (
    .ref_clk(ref_clk), .rst_n(rst_n), .ext_clk(ext_clk), .mon_en(mon_en),
    .osc_ready(osc_ready), .osc_restart(osc_restart), .sys_src(sys_src),
    .pll_from_ext(pll_from_ext), .nmi_clr(nmi_clr), .osc_off_req(osc_off_req),
    .pll_off_req(pll_off_req), .force_int_sel(force_int_sel),
    .brk_pulse(brk_pulse), .nmi_flag(nmi_flag)
  );

  // {sys_src, pll_from_ext, expect force, expect pll_off}
  localparam logic [4:0] VEC [4] = '{
    5'b01_0_1_0,  // R4 external direct
    5'b10_1_1_1,  // R5 PLL fed by external
    5'b10_0_0_0,  // R6 PLL fed internally
    5'b00_1_0_0   // R6 internal clock
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  task automatic bring_up;
    osc_restart = 1'b1; nmi_clr = 1'b1; osc_ready = 1'b0; ext_run = 1'b1;
    cyc(1);
    osc_restart = 1'b0; nmi_clr = 1'b0;
    cyc(6);
    osc_ready = 1'b1; mon_en = 1'b1;
    cyc(3 * WIN);
  endtask

  task automatic wait_fail(output int lat);
    lat = -1;
    for (int i = 1; i <= LAT + 20; i++) begin
      cyc(1);
      if (nmi_flag) begin lat = i; break; end
    end
  endtask

  initial begin
    int lat;
    cyc(3);
    check(!osc_off_req && !pll_off_req && !force_int_sel && !brk_pulse && !nmi_flag,
          "R1", {osc_off_req, pll_off_req, force_int_sel, brk_pulse, nmi_flag}, 0);
    rst_n = 1'b1;
    cyc(2);

    for (int v = 0; v < 4; v++) begin
      sys_src = VEC[v][4:3]; pll_from_ext = VEC[v][2];
      bring_up();
      cyc(8 * WIN);
      check(!nmi_flag && !osc_off_req, "R2", nmi_flag, 0);
      ext_run = 1'b0;
      wait_fail(lat);
      check(lat > 0 && lat <= LAT, "R3", lat, LAT);
      check(osc_off_req, "R3", osc_off_req, 1);
      check(brk_pulse, "R7", brk_pulse, 1);
      check(force_int_sel == VEC[v][1], "R4/R5/R6 force", force_int_sel, VEC[v][1]);
      check(pll_off_req == VEC[v][0], "R4/R5/R6 pll", pll_off_req, VEC[v][0]);
      cyc(1);
      check(!brk_pulse, "R7", brk_pulse, 0);
      cyc(20);
      check(nmi_flag, "R8", nmi_flag, 1);
      nmi_clr = 1'b1; cyc(1); nmi_clr = 1'b0;
      check(!nmi_flag, "R8", nmi_flag, 0);
    end

    // R10: restart without a new ready cycle must not re-arm
    osc_restart = 1'b1; cyc(1); osc_restart = 1'b0;
    check(!osc_off_req && !force_int_sel && !pll_off_req, "R10 restart clears",
          {osc_off_req, force_int_sel, pll_off_req}, 0);
    cyc(4 * WIN);
    check(!nmi_flag && !osc_off_req, "R10 no rearm", nmi_flag, 0);

    // R9: monitoring disabled
    sys_src = 2'b01; pll_from_ext = 1'b0;
    bring_up();
    mon_en = 1'b0; ext_run = 1'b0;
    cyc(4 * WIN);
    check(!nmi_flag && !osc_off_req && !force_int_sel, "R9 mon_en", nmi_flag, 0);
    // R9: oscillator not ready
    mon_en = 1'b1; osc_ready = 1'b0;
    cyc(4 * WIN);
    check(!nmi_flag && !osc_off_req, "R9 osc_ready", nmi_flag, 0);

    // R10: full restart re-arms
    bring_up();
    ext_run = 1'b0;
    wait_fail(lat);
    check(lat > 0 && osc_off_req && force_int_sel, "R10 rearm", lat, LAT);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule